// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the feedback divider of a frequency synthesizer. The oscillator clock is first halved by a toggle stage. It then passes through a prescaler whose modulus can be switched between P and P+1, where P is two to the power of the swallow-counter width. A main counter and a swallow counter close the loop. Over one full division cycle the block counts P·M + S prescaler input periods and emits a single one-cycle pulse toward the phase detector. The locked oscillator therefore runs at 2·f_ref·(P·M + S). With the default widths (10-bit M, 5-bit S, P = 32) this gives 2·f_ref·(32M + S).

The ratio inputs come from a control register elsewhere. They are sampled only when the block is idle, or at the edge that ends a division cycle, so no cycle mixes two ratios. A ratio with M = 0 or S ≥ M cannot be counted. When such a ratio is sampled, the block raises an error flag and stays idle, with no pulses and the modulus control low. It keeps sampling on every clock until it sees a legal ratio. After reset both ratios read as zero, so the block starts idle with the error flag set.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to its power-on state: `div_pulse` = 0, `mod_high` = 0, `cfg_err` = 1, and the held ratio is M = 0, S = 0.
- R2: In steady state with a legal ratio, rising edges of `div_pulse` are exactly 2·(P·M + S) clock cycles apart, where P = 2^SWAL_W.
- R3: `div_pulse` is high for exactly one clock cycle per division cycle.
- R4: In each division cycle `mod_high` is high for exactly 2·S·(P+1) clock cycles: the first S prescaler periods use modulus P+1, and the rest use P. `mod_high` changes only where a prescaler period ends.
- R5: A change of `main_ratio` or `swallow_ratio` during a division cycle does not alter the length of that cycle. The new ratio governs the cycle that begins at the next pulse.
- R6: If the ratio sampled at a cycle boundary, or while idle, has M = 0 or S ≥ M, then `cfg_err` goes to 1 on that edge. While it stays 1, the block gives no pulses and `mod_high` stays low.
- R7: When the block is idle and a legal ratio is applied, `cfg_err` clears on the next clock edge. The first pulse appears 2·(P·M + S) clock edges after that edge, so it is seen at the (2·(P·M + S) + 1)-th falling edge after the inputs change.
- R8: The extreme legal ratios divide correctly: S = M − 1, S = 0, M = 1, and the largest value of each field (M = 2^MAIN_W − 1 with S = P − 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock entering the fixed halving stage |
| rst_n | input | 1 | Synchronous active-low reset |
| main_ratio | input | MAIN_W | Main counter value M |
| swallow_ratio | input | SWAL_W | Swallow counter value S |
| div_pulse | output | 1 | One-cycle pulse that ends each division cycle |
| mod_high | output | 1 | Prescaler modulus select, 1 selects P+1 |
| cfg_err | output | 1 | Held ratio is not countable (M = 0 or S ≥ M) |

## Verification
Every result has a fixed latency. The error flag is registered, so it answers one edge after a ratio is sampled. The first pulse comes 2·(P·M+S) edges after a start from idle, and later pulses follow at that spacing. The bench drives inputs at falling edges and counts falling edges up to the expected edge before it samples, so each count includes the extra register stage of the pulse output. The pulse spacing, the time with `mod_high` high, and the error delay are all computed from M, S and P in the bench. A 2-bit-swallow, 4-bit-main instance is swept over all legal ratios, and the default instance is run at a small ratio and at the largest ratio.

// File: rtl/psd_pkg.sv
// Shared types and helpers for the pulse-swallow divider.
// Assumes ratio values fit in 32 bits.
package psd_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // A ratio can be counted only with a nonzero main value above the swallow value.
    function automatic logic ratio_ok(input int unsigned main_val,
                                      input int unsigned swal_val);
        return (main_val != 0) && (swal_val < main_val);
    endfunction

endpackage

// File: rtl/psd_half_stage.sv
// Fixed divide-by-two stage in front of the prescaler, modelled as a toggle.
// It gives a tick on every second clock while enabled. Assumes enable
// stays low while the divider is idle, so each run starts from phase zero.
module psd_half_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic half_tick
);

    logic phase_q;

    // Toggle the phase while enabled, and park it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign half_tick = enable & phase_q;

    // R2
    half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable)) |-> (half_tick != $past(half_tick)));

endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler model. It counts half-rate ticks and ends a
// period after BASE ticks, or BASE+1 when mod_high is set, with
// BASE = 2**SWAL_W. Assumes mod_high changes only where a period ends.
module psd_prescaler #(
    parameter int SWAL_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic half_tick,
    input  logic mod_high,
    output logic pre_tick
);

    localparam int BASE = 1 << SWAL_W;
    localparam int PW   = SWAL_W + 1;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] last_val;

    // Choose the final count value from the modulus currently selected.
    always_comb begin
        last_val = mod_high ? PW'(BASE) : PW'(BASE - 1);
    end

    assign pre_tick = half_tick && (cnt_q == last_val);

    // Advance on each half-rate tick, and wrap when a period ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (half_tick) begin
            cnt_q <= pre_tick ? '0 : cnt_q + 1'b1;
        end
    end

    // R4
    mod_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (mod_high != $past(mod_high))) |-> $past(pre_tick));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_high && enable) |-> (cnt_q < PW'(BASE)));

endmodule

// File: rtl/psd_ms_control.sv
// Main and swallow counters with the ratio hold register and error check.
// The ratio is sampled while idle or at the edge that ends a cycle.
// Assumes pre_tick marks the end of one prescaler period.
module psd_ms_control
    import psd_pkg::*;
#(
    parameter int MAIN_W = 10,
    parameter int SWAL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] m_in,
    input  logic [SWAL_W-1:0] s_in,
    input  logic              pre_tick,
    output logic              run,
    output logic              mod_high,
    output logic              div_pulse,
    output logic              cfg_err
);

    run_state_e        state_q;
    logic [MAIN_W-1:0] mc_q;
    logic [SWAL_W-1:0] sc_q;
    logic [MAIN_W-1:0] m_q;
    logic [SWAL_W-1:0] s_q;
    logic              err_q;
    logic              pulse_q;
    logic              in_ok;
    logic              last_tick;

    // Check whether the ratio at the inputs can be counted.
    always_comb begin
        in_ok = ratio_ok(32'(m_in), 32'(s_in));
    end

    // The end of a division cycle is the prescaler period that meets a main count of one.
    always_comb begin
        last_tick = (state_q == ST_RUN) && pre_tick && (mc_q == MAIN_W'(1));
    end

    // Sample or hold the ratio, and step both counters on each prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mc_q    <= '0;
            sc_q    <= '0;
            m_q     <= '0;
            s_q     <= '0;
            err_q   <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= last_tick;
            if ((state_q == ST_IDLE) || last_tick) begin
                m_q   <= m_in;
                s_q   <= s_in;
                err_q <= !in_ok;
                if (in_ok) begin
                    state_q <= ST_RUN;
                    mc_q    <= m_in;
                    sc_q    <= s_in;
                end else begin
                    state_q <= ST_IDLE;
                    mc_q    <= '0;
                    sc_q    <= '0;
                end
            end else if (pre_tick) begin
                mc_q <= mc_q - 1'b1;
                if (sc_q != '0) begin
                    sc_q <= sc_q - 1'b1;
                end
            end
        end
    end

    assign run       = (state_q == ST_RUN);
    assign mod_high  = run && (sc_q != '0);
    assign div_pulse = pulse_q;
    assign cfg_err   = err_q;

    // R2
    swallow_below_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (32'(sc_q) < 32'(mc_q)));

    // R5
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(last_tick)) |-> ($stable(m_q) && $stable(s_q)));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !mod_high);

    // R6
    err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $past(cfg_err)) |-> !div_pulse);

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

endmodule

// File: rtl/pulse_swallow_divider.sv
// Top of the pulse-swallow feedback divider. One div_pulse marks every
// 2*(2**SWAL_W * M + S) clocks. Assumes the ratio inputs come from a
// register in the same clock domain.
module pulse_swallow_divider #(
    parameter int MAIN_W = 10,
    parameter int SWAL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAIN_W-1:0] main_ratio,
    input  logic [SWAL_W-1:0] swallow_ratio,
    output logic              div_pulse,
    output logic              mod_high,
    output logic              cfg_err
);

    logic run;
    logic half_tick;
    logic pre_tick;

    psd_half_stage u_half (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (run),
        .half_tick (half_tick)
    );

    psd_prescaler #(.SWAL_W(SWAL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (run),
        .half_tick (half_tick),
        .mod_high  (mod_high),
        .pre_tick  (pre_tick)
    );

    psd_ms_control #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .m_in      (main_ratio),
        .s_in      (swallow_ratio),
        .pre_tick  (pre_tick),
        .run       (run),
        .mod_high  (mod_high),
        .div_pulse (div_pulse),
        .cfg_err   (cfg_err)
    );

endmodule

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SM_P       = 4;
    localparam int BIG_P      = 32;
    localparam int LIMIT      = 70000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] big_m = '0;
    logic [4:0] big_s = '0;
    logic [3:0] sm_m = '0;
    logic [1:0] sm_s = '0;
    logic big_pulse, big_mod, big_err;
    logic sm_pulse, sm_mod, sm_err;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pulse_swallow_divider u_pulse_swallow_divider (
        .clk(clk), .rst_n(rst_n), .main_ratio(big_m), .swallow_ratio(big_s),
        .div_pulse(big_pulse), .mod_high(big_mod), .cfg_err(big_err));

    pulse_swallow_divider #(.MAIN_W(4), .SWAL_W(2)) u_pulse_swallow_divider_small (
        .clk(clk), .rst_n(rst_n), .main_ratio(sm_m), .swallow_ratio(sm_s),
        .div_pulse(sm_pulse), .mod_high(sm_mod), .cfg_err(sm_err));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pulse_of(input bit sel);
        return sel ? big_pulse : sm_pulse;
    endfunction
    function automatic logic mod_of(input bit sel);
        return sel ? big_mod : sm_mod;
    endfunction
    function automatic logic err_of(input bit sel);
        return sel ? big_err : sm_err;
    endfunction

    task automatic set_cfg(input bit sel, input int m, input int s);
        if (sel) begin
            big_m = 10'(m);
            big_s = 5'(s);
        end else begin
            sm_m = 4'(m);
            sm_s = 2'(s);
        end
    endtask

    task automatic wait_err(input bit sel);
        int n = 0;
        while (!err_of(sel) && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_pulse(input bit sel, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse_of(sel) && n < LIMIT);
    endtask

    // Starts at a falling edge that shows a pulse, and returns at the next one.
    task automatic measure_period(input bit sel, output int len, output int modc, output int second);
        modc = int'(mod_of(sel));
        len = 0;
        second = 0;
        forever begin
            @(negedge clk);
            len++;
            if (len == 1) second = int'(pulse_of(sel));
            if (pulse_of(sel) || len > LIMIT) break;
            modc += int'(mod_of(sel));
        end
    endtask

    task automatic run_pair(input bit sel, input int m, input int s, input int p, input string tag);
        int n, first, len, modc, second;
        n = p * m + s;
        set_cfg(sel, 0, 0);
        wait_err(sel);
        set_cfg(sel, m, s);
        @(negedge clk);
        // R7: error clears one edge after a legal ratio is applied
        check(err_of(sel) == 1'b0, "R7 err clear", int'(err_of(sel)), 0);
        first = 1;
        while (!pulse_of(sel) && first < LIMIT) begin
            @(negedge clk);
            first++;
        end
        check(first == 2 * n + 1, "R7 first pulse", first, 2 * n + 1);
        measure_period(sel, len, modc, second);
        check(len == 2 * n, tag, len, 2 * n);
        check(second == 0, "R3 pulse width", second, 0);
        check(modc == 2 * s * (p + 1), "R4 modulus time", modc, 2 * s * (p + 1));
    endtask

    task automatic watch_quiet(input bit sel, input int cycles, input string tag);
        int pulses = 0;
        int mods = 0;
        int errs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            pulses += int'(pulse_of(sel));
            mods += int'(mod_of(sel));
            errs += int'(!err_of(sel));
        end
        check(pulses == 0, {tag, " pulses"}, pulses, 0);
        check(mods == 0, {tag, " mod_high"}, mods, 0);
        check(errs == 0, {tag, " err held"}, errs, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int n, len, modc, second;
        repeat (3) @(negedge clk);
        // R1: power-on state during reset
        check(big_pulse == 0 && big_mod == 0, "R1 big outputs", int'({big_pulse, big_mod}), 0);
        check(big_err == 1, "R1 big err", int'(big_err), 1);
        check(sm_pulse == 0 && sm_mod == 0 && sm_err == 1, "R1 small state",
              int'({sm_pulse, sm_mod, sm_err}), 1);
        rst_n = 1'b1;
        // R6: zero ratio after reset keeps the block idle
        watch_quiet(0, 40, "R6 zero ratio");

        // R2 sweep of all legal small ratios, R8 boundaries included
        for (int m = 1; m < 16; m++) begin
            for (int s = 0; s < SM_P && s < m; s++) begin
                run_pair(0, m, s, SM_P, (s == m - 1 || s == 0 || m == 15) ? "R8 boundary period" : "R2 period");
            end
        end

        // R5: a mid-cycle change leaves the running cycle alone
        run_pair(0, 5, 2, SM_P, "R2 period");
        repeat (10) @(negedge clk);
        set_cfg(0, 9, 1);
        wait_pulse(0, n);
        check(n == 2 * 22 - 10, "R5 current cycle", n, 2 * 22 - 10);
        measure_period(0, len, modc, second);
        check(len == 2 * 37, "R5 next cycle", len, 2 * 37);

        // R6: S equal to M, S above M, and M of zero
        run_pair(0, 3, 1, SM_P, "R2 period");
        set_cfg(0, 3, 3);
        wait_err(0);
        watch_quiet(0, 100, "R6 s equals m");
        set_cfg(0, 2, 3);
        watch_quiet(0, 60, "R6 s above m");
        set_cfg(0, 0, 2);
        watch_quiet(0, 60, "R6 m zero");

        // Default widths: a small ratio, then the largest ratio
        run_pair(1, 3, 2, BIG_P, "R2 default period");
        set_cfg(1, 1023, 31);
        wait_pulse(1, n);
        check(n == 2 * 98, "R5 default current cycle", n, 2 * 98);
        measure_period(1, len, modc, second);
        check(len == 2 * 32767, "R8 largest ratio", len, 2 * 32767);
        check(modc == 2 * 31 * 33, "R4 largest ratio modulus", modc, 2 * 31 * 33);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule